// File: doc/BRIEF.md
# Converter Result and Status Register Bank

This block collects the results of a multi-channel analog-to-digital converter. Each time the converter finishes a conversion it pulses a done strobe along with the channel number and the 12-bit sample. The bank stores the sample in that channel's own result register. It also keeps two flags per channel. The valid flag means there is an unread sample. The overrun flag means a sample was overwritten before anyone read it.

Software reaches the bank over a simple single-cycle register bus. The result registers sit at addresses 0 to NUM_CH-1. The status register sits at NUM_CH and the control register at NUM_CH+1. The status register holds the shared event flags, the live busy indication and the per-channel valid and overrun bits. The shared flags are conversion done, comparator 0 hit and comparator 1 hit. They clear when software writes a one to them. Reading a result register consumes the sample, which clears that channel's valid and overrun flags. Each shared flag drives an interrupt request through an enable bit in the control register.

Top module: `adc_result_bank`

## Requirements
- R1: When `res_valid` is 1 at a clock edge, `res_data` is stored in the result register of channel `res_chan`. Reading address `ch` (below NUM_CH) returns that value in `bus_rdata[11:0]`. All other channels keep their values.
- R2: A stored result sets that channel's valid flag. The flag reads at bit 16 of the channel's result register and at bit 8+ch of the status register.
- R3: A result that arrives for a channel whose valid flag is already 1 sets the channel's overrun flag, unless that channel's result register is read in the same cycle. The overrun flag reads at bit 17 of the result register and at bit 16+ch of the status register. It is never 1 while the valid flag is 0.
- R4: A read of a channel's result register returns the current contents and then clears that channel's valid and overrun flags. If a new result for the same channel arrives in that same cycle, the new value is stored with valid 1 and overrun 0.
- R5: Reading the status or control register changes no state. Writes to result registers or to unmapped addresses are ignored. Unmapped addresses read as zero.
- R6: Status bit 0 (done) sets on every `res_valid`. Bit 1 (comparator 0) sets on `cmp_evt[0]`. Bit 2 (comparator 1) sets on `cmp_evt[1]`.
- R7: A write to the status register clears each of bits 2:0 whose `bus_wdata` bit is 1 and leaves the others unchanged. A set event in the same cycle takes precedence over the clear.
- R8: Status bit 3 shows `conv_busy` in the same cycle, with no register delay.
- R9: The control register holds interrupt enables in bits 2:0 (done, comparator 0, comparator 1), written and read back at address NUM_CH+1. Each interrupt output is 1 exactly when its flag and its enable are both 1.
- R10: After reset every result, flag and enable is 0, and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion done strobe |
| res_chan | input | CH_W | Channel of the finished conversion |
| res_data | input | DATA_W | Conversion sample |
| cmp_evt | input | 2 | Comparator match pulses |
| conv_busy | input | 1 | Converter is converting |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_done | output | 1 | Conversion-done interrupt request |
| irq_cmp0 | output | 1 | Comparator 0 interrupt request |
| irq_cmp1 | output | 1 | Comparator 1 interrupt request |

## Verification
The bench builds the block with its defaults: eight channels, 12-bit samples and a 4-bit address. With these values, random addresses reach all eight result registers and the status and control registers. They also reach six unmapped addresses. Random results across only eight channels make back-to-back overruns common. Reads that collide with a new result on the same channel also happen often enough to exercise the read-versus-store rule and the set-over-clear precedence of the status flags.

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data,
  input  logic [1:0]        cmp_evt,
  input  logic              conv_busy,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_done,
  output logic              irq_cmp0,
  output logic              irq_cmp1
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(NUM_CH + 1);
  localparam int VLD_BASE = 8;
  localparam int OVR_BASE = VLD_BASE + NUM_CH;
  localparam int DV_BIT = 16;
  localparam int DO_BIT = 17;

  logic [DATA_W-1:0] res_q [NUM_CH];
  logic [NUM_CH-1:0] valid_q, ovr_q;
  logic [2:0]        flag_q, en_q;

  wire in_data  = bus_addr < ADDR_W'(NUM_CH);
  wire stat_wr  = bus_wr && bus_addr == STAT_A;
  wire [CH_W-1:0] sel = bus_addr[CH_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wire rd_c = bus_rd && bus_addr == ADDR_W'(c);
    wire wr_c = res_valid && res_chan == CH_W'(c);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q[c]   <= '0;
        valid_q[c] <= 1'b0;
        ovr_q[c]   <= 1'b0;
      end else begin
        if (wr_c) res_q[c] <= res_data;
        valid_q[c] <= wr_c | (valid_q[c] & ~rd_c);
        ovr_q[c]   <= wr_c ? (~rd_c & (ovr_q[c] | valid_q[c])) : (ovr_q[c] & ~rd_c);
      end
    end
  end

  wire [2:0] set_v = {cmp_evt[1], cmp_evt[0], res_valid};
  wire [2:0] clr_v = stat_wr ? bus_wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_v) | set_v;
      if (bus_wr && bus_addr == CTRL_A) en_q <= bus_wdata[2:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_data) begin
      bus_rdata[DATA_W-1:0] = res_q[sel];
      bus_rdata[DV_BIT]     = valid_q[sel];
      bus_rdata[DO_BIT]     = ovr_q[sel];
    end else if (bus_addr == STAT_A) begin
      bus_rdata[2:0] = flag_q;
      bus_rdata[3]   = conv_busy;
      bus_rdata[VLD_BASE +: NUM_CH] = valid_q;
      bus_rdata[OVR_BASE +: NUM_CH] = ovr_q;
    end else if (bus_addr == CTRL_A) begin
      bus_rdata[2:0] = en_q;
    end
  end

  assign irq_done = flag_q[0] & en_q[0];
  assign irq_cmp0 = flag_q[1] & en_q[1];
  assign irq_cmp1 = flag_q[2] & en_q[2];
endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [CH_W-1:0]   res_chan,
  input logic [1:0]        cmp_evt,
  input logic              conv_busy,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] valid_q,
  input logic [NUM_CH-1:0] ovr_q,
  input logic [2:0]        flag_q,
  input logic [2:0]        en_q,
  input logic              irq_done
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NUM_CH);

  assert_valid_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> valid_q[$past(res_chan)]);

  assert_ovr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && valid_q[res_chan] && !(bus_rd && bus_addr == ADDR_W'(res_chan))
    |=> ovr_q[$past(res_chan)]);

  assert_ovr_implies_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q & ~valid_q) == '0);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr < ADDR_W'(NUM_CH) && !(res_valid && ADDR_W'(res_chan) == bus_addr)
    |=> !valid_q[$past(bus_addr[CH_W-1:0])] && !ovr_q[$past(bus_addr[CH_W-1:0])]);

  assert_done_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> flag_q[0]);

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == STAT_A && bus_wdata[1] && !cmp_evt[0] |=> !flag_q[1]);

  assert_busy_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == STAT_A |-> bus_rdata[3] == conv_busy);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[0] |-> !irq_done);
endmodule

bind adc_result_bank adc_result_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
  .cmp_evt(cmp_evt), .conv_busy(conv_busy), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .valid_q(valid_q), .ovr_q(ovr_q), .flag_q(flag_q), .en_q(en_q),
  .irq_done(irq_done)
);

// File: tb/adc_result_bank_tb.sv
module adc_result_bank_tb;
  localparam int NCH = 8;
  localparam int DW  = 12;
  localparam int AW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0;
  logic [2:0] res_chan = '0;
  logic [DW-1:0] res_data = '0;
  logic [1:0] cmp_evt = '0;
  logic conv_busy = 1'b0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_done, irq_cmp0, irq_cmp1;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  logic [DW-1:0] m_res [NCH];
  logic [NCH-1:0] m_val = '0, m_ovr = '0;
  logic [2:0] m_flag = '0, m_en = '0;

  always #10 clk = ~clk;

  adc_result_bank #(.NUM_CH(NCH), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .cmp_evt(cmp_evt), .conv_busy(conv_busy),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_done(irq_done), .irq_cmp0(irq_cmp0), .irq_cmp1(irq_cmp1)
  );

  function automatic logic [31:0] exp_read(int a, logic busy);
    logic [31:0] r = '0;
    if (a < NCH) begin
      r[DW-1:0] = m_res[a];
      r[16] = m_val[a];
      r[17] = m_ovr[a];
    end else if (a == NCH) begin
      r[2:0] = m_flag;
      r[3] = busy;
      r[15:8] = m_val;
      r[23:16] = m_ovr;
    end else if (a == NCH + 1) begin
      r[2:0] = m_en;
    end
    return r;
  endfunction

  function automatic string tag_for(int a);
    if (a < NCH) return "R1/R2/R3/R4";
    if (a == NCH) return "R2/R3/R6/R7/R8";
    if (a == NCH + 1) return "R9";
    return "R5";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic rv, int ch, int d, logic rd, logic wr, int a, int wd,
                      logic [1:0] ce, logic busy, string req = "");
    @(negedge clk);
    res_valid = rv; res_chan = 3'(ch); res_data = DW'(d);
    bus_rd = rd; bus_wr = wr; bus_addr = AW'(a); bus_wdata = 32'(wd);
    cmp_evt = ce; conv_busy = busy;
    #2;
    if (rd) check(req == "" ? tag_for(a) : req, bus_rdata, exp_read(a, busy));
    check("R9 irq", {29'd0, irq_cmp1, irq_cmp0, irq_done}, m_flag & m_en);
    @(posedge clk);
    #1;
    for (int c = 0; c < NCH; c++) begin
      bit rdc = rd && a == c;
      bit wrc = rv && ch == c;
      if (wrc) begin
        m_res[c] = DW'(d);
        m_ovr[c] = !rdc && (m_ovr[c] || m_val[c]);
        m_val[c] = 1'b1;
      end else if (rdc) begin
        m_val[c] = 1'b0;
        m_ovr[c] = 1'b0;
      end
    end
    if (wr && a == NCH) m_flag = m_flag & ~wd[2:0];
    m_flag = m_flag | {ce[1], ce[0], rv};
    if (wr && a == NCH + 1) m_en = wd[2:0];
  endtask

  task automatic idle_read(int a, string req = "");
    step(0, 0, 0, 1, 0, a, 0, 2'b00, 0, req);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int c = 0; c < NCH; c++) m_res[c] = '0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    for (int a = 0; a < 16; a++) idle_read(a, "R10 reset");

    step(1, 3, 'hABC, 0, 0, 0, 0, 2'b00, 0);
    idle_read(3, "R1/R2 store");
    idle_read(3, "R4 read clears");

    step(1, 5, 'h111, 0, 0, 0, 0, 2'b00, 0);
    step(1, 5, 'h222, 0, 0, 0, 0, 2'b00, 0);
    idle_read(NCH, "R3 overrun in status");
    idle_read(5, "R3 overrun in data reg");
    idle_read(5, "R4 overrun cleared");

    step(1, 2, 'h0F0, 0, 0, 0, 0, 2'b00, 0);
    step(1, 2, 'hF0F, 1, 0, 2, 0, 2'b00, 0, "R4 collide read");
    idle_read(2, "R4 collide after");

    step(0, 0, 0, 0, 1, 1, 'h3FFFF, 2'b00, 0);
    idle_read(1, "R5 write to data ignored");
    step(0, 0, 0, 0, 1, 12, -1, 2'b00, 0);
    idle_read(NCH, "R5 status after unmapped write");
    idle_read(NCH, "R5 status read has no side effect");

    step(0, 0, 0, 0, 1, NCH + 1, 'h7, 2'b11, 0);
    idle_read(NCH + 1, "R9 enables readback");
    step(0, 0, 0, 0, 0, 0, 0, 2'b00, 0);
    step(0, 0, 0, 0, 1, NCH, 'h2, 2'b00, 0);
    idle_read(NCH, "R7 w1c single bit");
    step(1, 0, 'h5, 0, 1, NCH, 'h7, 2'b10, 0);
    idle_read(NCH, "R7 set wins over clear");
    step(0, 0, 0, 1, 0, NCH, 0, 2'b00, 1, "R8 busy high");
    step(0, 0, 0, 1, 0, NCH, 0, 2'b00, 0, "R8 busy low");

    for (int i = 0; i < 4000; i++) begin
      logic rv = ($urandom % 10) < 4;
      int ch = $urandom % NCH;
      int d = $urandom % (1 << DW);
      logic rd = ($urandom % 2) == 1;
      logic wr = ($urandom % 5) == 0;
      int a = $urandom % 16;
      int wd = $urandom;
      logic [1:0] ce = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      logic busy = 1'($urandom);
      step(rv, ch, d, rd, wr, a, wd, ce, busy);
    end

    for (int a = 0; a < 16; a++) idle_read(a);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule